// File: doc/BRIEF.md
# Mixed-Mode Interrupt Status Controller

This block sits between a set of peripheral interrupt lines and a processor. It keeps one status bit per interrupt source. Each source is set up on its own as level-sensitive or edge-sensitive, so the two kinds can share one status word. No separate acknowledge register is needed.

A level-sensitive bit shows the registered level of its input. It never latches. It drops one clock after the device withdraws its request, and bus writes do not change it. An edge-sensitive bit is set by a rising edge of the registered input. It stays set until software writes a 1 to that bit position. Writing a 0 to a bit leaves it as it is, so one write can clear any chosen set of pending edges without a read-modify-write.

A mask register selects which status bits can drive the single interrupt request line to the processor. Masking only gates the request line: status bits are captured whether or not they are masked. All registers are reached through a small single-cycle register bus. Writes take effect at the clock edge on which the write strobe is sampled. Read data is combinational from the address.

Top module: `isc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word, the mask register (address 1) and the mode register (address 2) all read zero, and `irq_o` is low.
- R2: A source in level mode shows in its status bit the value its input had at the previous rising clock edge: it sets one clock after the input rises and clears one clock after the input falls.
- R3: A bus write of any value to the status word (address 0) does not change any bit whose source is in level mode.
- R4: In edge mode, a 0-to-1 change of the registered input sets the status bit at the second clock edge after the input rises. The bit then stays set after the input falls.
- R5: A write to address 0 clears every edge-mode bit whose data bit is 1. It leaves every edge-mode bit whose data bit is 0 unchanged.
- R6: When a new rising edge of a source is detected on the same clock edge as a write-1 clear of its bit, the bit stays set.
- R7: Level-mode and edge-mode sources coexist in one status word, each bit obeying its own mode.
- R8: `irq_o` is high exactly when some status bit and the matching mask bit are both 1. A masked source still records its status bit.
- R9: The mask register (address 1) and the mode register (address 2, bit value 1 = edge, 0 = level) read back the last value written. Address 3 reads zero.
- R10: An input held high when its bit is switched to edge mode does not set the bit. Switching an edge bit to level mode discards its latched edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Interrupt inputs from the peripherals |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write strobe, qualified by `bus_sel_i` |
| bus_addr_i | input | 2 | Register address: 0 status, 1 mask, 2 mode |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Read data of the addressed register |
| status_o | output | N_SRC | Current status word |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The assertions assume that each interrupt input is a clean synchronous signal that is stable around the clock edge. They also assume that a bus write lasts exactly the cycle in which its strobe is sampled. The bench changes inputs and strobes only on the falling clock edge and drops each write strobe one cycle after raising it. It leaves each pulse long enough to be registered. The set-versus-clear race is produced on purpose by lining up the status write with the cycle in which the new edge is detected.

// File: rtl/isc_pkg.sv
// Package: shared address map and sizes for the interrupt status controller.
// Assumes a two-bit register address; all other widths come from parameters.
package isc_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_MODE   = 2'd2,
        REG_NONE   = 2'd3
    } isc_reg_e;
endpackage

// File: rtl/isc_bus_decode.sv
// Module: isc_bus_decode
// Turns single-cycle bus accesses into per-register write strobes and
// selects read data. Assumes a write lasts one sampled cycle; reads have
// no side effects and are combinational from the address.
module isc_bus_decode
    import isc_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [N_SRC-1:0]     status_i,
    input  logic [N_SRC-1:0]     mask_i,
    input  logic [N_SRC-1:0]     mode_i,
    output logic                 status_we_o,
    output logic                 mask_we_o,
    output logic                 mode_we_o,
    output logic [N_SRC-1:0]     rdata_o
);
    logic     wr_ok;
    isc_reg_e reg_sel;

    assign wr_ok   = sel_i && we_i;
    assign reg_sel = isc_reg_e'(addr_i);

    // Write strobe decode: one register per sampled write.
    always_comb begin
        status_we_o = 1'b0;
        mask_we_o   = 1'b0;
        mode_we_o   = 1'b0;
        if (wr_ok) begin
            case (reg_sel)
                REG_STATUS: status_we_o = 1'b1;
                REG_MASK:   mask_we_o   = 1'b1;
                REG_MODE:   mode_we_o   = 1'b1;
                default:    ;
            endcase
        end
    end

    // Read data selection; unused address returns zero.
    always_comb begin
        case (reg_sel)
            REG_STATUS: rdata_o = status_i;
            REG_MASK:   rdata_o = mask_i;
            REG_MODE:   rdata_o = mode_i;
            default:    rdata_o = '0;
        endcase
    end

    // At most one register is written per cycle (R9).
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_we_o, mask_we_o, mode_we_o}));
endmodule

// File: rtl/isc_src_cell.sv
// Module: isc_src_cell
// One interrupt source: registers the input, keeps the previous sample,
// holds the per-source mode bit and the edge latch, and forms the status
// bit. Assumes src_i is synchronous to clk.
module isc_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic mode_we_i,
    input  logic mode_d_i,
    input  logic clr_we_i,
    input  logic clr_d_i,
    output logic edge_mode_o,
    output logic status_o
);
    logic smp_q;
    logic prev_q;
    logic mode_q;
    logic latch_q;
    logic rise;
    logic clr_hit;
    logic past_ok_q;

    assign rise    = smp_q && !prev_q;
    assign clr_hit = clr_we_i && clr_d_i;

    // Input sampling and previous-sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            smp_q  <= src_i;
            prev_q <= smp_q;
        end
    end

    // Trigger mode bit: 1 selects edge, 0 selects level.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= 1'b0;
        else if (mode_we_i) mode_q <= mode_d_i;
    end

    // Edge latch: a detected rise beats a same-cycle clear; idle in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= 1'b0;
        else if (!mode_q) latch_q <= 1'b0;
        else if (rise)    latch_q <= 1'b1;
        else if (clr_hit) latch_q <= 1'b0;
    end

    // Marks that one sample has been taken since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assign edge_mode_o = mode_q;
    assign status_o    = mode_q ? latch_q : smp_q;

    // Level bit equals the input one clock earlier (R2, R3).
    assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !mode_q) |-> (status_o == $past(src_i)));

    // A write-1 with no new edge clears an edge bit that stays in edge mode (R5).
    assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !(mode_we_i && !mode_d_i) && clr_hit && !(smp_q && !prev_q))
        |=> !status_o);

    // A set edge bit holds when not cleared and still in edge mode (R5).
    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !(mode_we_i && !mode_d_i) && status_o && !clr_hit) |=> status_o);

    // A detected rise sets the bit even against a clear (R6).
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !(mode_we_i && !mode_d_i) && smp_q && !prev_q) |=> status_o);
endmodule

// File: rtl/isc_mask_irq.sv
// Module: isc_mask_irq
// Holds the mask register and forms the combined request line. Assumes
// the status word arrives from registers, so irq_o has no input path.
module isc_mask_irq #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] mask_d_i,
    input  logic [N_SRC-1:0] status_i,
    output logic [N_SRC-1:0] mask_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] mask_q;

    // Mask register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_d_i;
    end

    assign mask_o = mask_q;
    assign irq_o  = |(status_i & mask_q);

    // Writing an all-zero mask silences the request line next cycle (R8).
    assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && (mask_d_i == '0)) |=> !irq_o);
endmodule

// File: rtl/isc_ctrl.sv
// Module: isc_ctrl (top)
// Mixed-mode interrupt status controller: one status bit per source, each
// source level- or edge-triggered, edge bits cleared by writing 1, and a
// masked combined request. Assumes synchronous inputs and one-cycle writes.
module isc_ctrl
    import isc_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [N_SRC-1:0]     bus_wdata_i,
    output logic [N_SRC-1:0]     bus_rdata_o,
    output logic [N_SRC-1:0]     status_o,
    output logic                 irq_o
);
    logic             status_we;
    logic             mask_we;
    logic             mode_we;
    logic [N_SRC-1:0] mask_w;
    logic [N_SRC-1:0] mode_w;
    logic [N_SRC-1:0] status_w;

    isc_bus_decode #(.N_SRC(N_SRC)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (bus_sel_i),
        .we_i        (bus_we_i),
        .addr_i      (bus_addr_i),
        .status_i    (status_w),
        .mask_i      (mask_w),
        .mode_i      (mode_w),
        .status_we_o (status_we),
        .mask_we_o   (mask_we),
        .mode_we_o   (mode_we),
        .rdata_o     (bus_rdata_o)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        isc_src_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (src_i[i]),
            .mode_we_i   (mode_we),
            .mode_d_i    (bus_wdata_i[i]),
            .clr_we_i    (status_we),
            .clr_d_i     (bus_wdata_i[i]),
            .edge_mode_o (mode_w[i]),
            .status_o    (status_w[i])
        );
    end

    isc_mask_irq #(.N_SRC(N_SRC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask_we),
        .mask_d_i  (bus_wdata_i),
        .status_i  (status_w),
        .mask_o    (mask_w),
        .irq_o     (irq_o)
    );

    assign status_o = status_w;
endmodule

// File: tb/tb_isc_ctrl.sv
module tb_isc_ctrl;
    localparam int N = 8;
    localparam int A_STAT = 0, A_MASK = 1, A_MODE = 2, A_NONE = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         sel = 1'b0;
    logic         we = 1'b0;
    logic [1:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] status;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    isc_ctrl #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .status_o(status), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // One-cycle write, applied at the rising edge between two falling edges.
    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [N-1:0] v;
        rd(A_STAT, v); chk("R1 status", v, '0);
        rd(A_MASK, v); chk("R1 mask", v, '0);
        rd(A_MODE, v); chk("R1 mode", v, '0);
        chk("R1 irq", N'(irq), '0);
    endtask

    task automatic t_level;
        @(negedge clk); src[2] = 1'b1; #1;
        chk("R2 not yet", status, '0);
        cyc(1);
        chk("R2 set", status, 8'h04);
        src[2] = 1'b0; #1;
        chk("R2 still set", status, 8'h04);
        cyc(1);
        chk("R2 cleared", status, 8'h00);
    endtask

    task automatic t_level_write;
        logic [N-1:0] v;
        @(negedge clk); src[3] = 1'b1;
        cyc(1);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v); chk("R3 write1 high", v, 8'h08);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); chk("R3 write0 high", v, 8'h08);
        src[3] = 1'b0;
        cyc(1);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v); chk("R3 write1 low", v, 8'h00);
    endtask

    task automatic t_edge;
        logic [N-1:0] v;
        wr(A_MODE, 8'h30);
        @(negedge clk); src[4] = 1'b1; src[5] = 1'b1;
        @(negedge clk); src[4] = 1'b0; src[5] = 1'b0; #1;
        chk("R4 not yet", status, 8'h00);
        cyc(1);
        chk("R4 latched", status, 8'h30);
        cyc(3);
        chk("R4 held", status, 8'h30);
        wr(A_STAT, 8'h10);
        rd(A_STAT, v); chk("R5 clear one", v, 8'h20);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v); chk("R5 write0 keeps", v, 8'h20);
        wr(A_STAT, 8'h20);
        rd(A_STAT, v); chk("R5 clear other", v, 8'h00);
    endtask

    task automatic t_set_wins;
        logic [N-1:0] v;
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); src[4] = 1'b0;
        cyc(2);
        chk("R6 pre set", status, 8'h10);
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = A_STAT; wdata = 8'h10;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; wdata = '0;
        rd(A_STAT, v); chk("R6 set wins", v, 8'h10);
        wr(A_STAT, 8'h10);
        rd(A_STAT, v); chk("R5 clear while high", v, 8'h00);
        src[4] = 1'b0;
        cyc(2);
    endtask

    task automatic t_mixed;
        logic [N-1:0] v;
        @(negedge clk); src[1] = 1'b1; src[5] = 1'b1;
        @(negedge clk); src[5] = 1'b0;
        cyc(1);
        rd(A_STAT, v); chk("R7 both", v, 8'h22);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v); chk("R7 only edge cleared", v, 8'h02);
    endtask

    task automatic t_mask;
        #1; chk("R8 masked irq", N'(irq), 8'h00);
        wr(A_MASK, 8'h02); #1;
        chk("R8 unmasked irq", N'(irq), 8'h01);
        wr(A_MASK, 8'h00); #1;
        chk("R8 remasked irq", N'(irq), 8'h00);
        src[1] = 1'b0;
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk); src[5] = 1'b0;
        cyc(1);
        chk("R8 masked capture", status, 8'h20);
        wr(A_MASK, 8'h20); #1;
        chk("R8 edge irq", N'(irq), 8'h01);
        wr(A_STAT, 8'h20); #1;
        chk("R8 irq after clear", N'(irq), 8'h00);
    endtask

    task automatic t_regs;
        logic [N-1:0] v;
        wr(A_MASK, 8'hA5);
        rd(A_MASK, v); chk("R9 mask", v, 8'hA5);
        rd(A_MODE, v); chk("R9 mode", v, 8'h30);
        wr(A_NONE, 8'hFF);
        rd(A_NONE, v); chk("R9 spare", v, 8'h00);
        rd(A_MASK, v); chk("R9 mask kept", v, 8'hA5);
        wr(A_MASK, 8'h00);
    endtask

    task automatic t_mode_switch;
        logic [N-1:0] v;
        @(negedge clk); src[6] = 1'b1;
        cyc(2);
        chk("R10 level high", status, 8'h40);
        wr(A_MODE, 8'h70);
        cyc(2);
        rd(A_STAT, v); chk("R10 no edge", v, 8'h00);
        src[6] = 1'b0;
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); src[4] = 1'b0;
        cyc(1);
        chk("R10 latched", status, 8'h10);
        wr(A_MODE, 8'h60);
        wr(A_MODE, 8'h70);
        rd(A_STAT, v); chk("R10 discarded", v, 8'h00);
    endtask

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_level();
        t_level_write();
        t_edge();
        t_set_wins();
        t_mixed();
        t_mask();
        t_regs();
        t_mode_switch();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule